// File: doc/BRIEF.md
# Triggered Spectral Acquisition Sequencer

This block runs one spectral scan of a linear image sensor. A rising edge on either of two equivalent start inputs (a buffer-clear line and an external trigger) begins a scan. The block then waits a fixed setup delay and opens an integration window whose length is given in milliseconds. After the window closes it captures a fixed number of digitised pixel samples into an on-chip pixel buffer. The first sample of a scan is the first optical-black pixel.

A ready flag stays high whenever at least one unread pixel word is waiting. A pop strobe moves the oldest word into an output holding register for the serial host interface to shift out. The host may stop reading at any point. A new start edge in any phase aborts the scan, empties the buffer and begins a fresh acquisition.

The start inputs are taken as synchronous to the block clock. The sensor clocking, the ADC and the serial framing are outside the block: the ADC side appears as a sample-valid strobe with data, and the host side appears as the pop strobe.

Top module: `spec_acq_seq`

## Requirements
- R1: A 0-to-1 transition on `fifo_rst_i` or on `trig_i` starts a scan, and the two inputs act identically. An input held high does not start another scan.
- R2: After the start edge is sampled, `integ_o` stays low for SETUP_CYCLES clock cycles and then goes high.
- R3: `integ_o` stays high for N*MS_CYCLES cycles. N is the value on `int_ms_i` at the moment integration begins.
- R4: An `int_ms_i` value of 0 gives the same window as a value of 1.
- R5: `xfer_o` is high during the first XFER_CYCLES cycles of each integration window, which is the sensor's pixel transfer and reset time. It is low at all other times.
- R6: Pixel samples are stored only in the readout phase that follows integration. Exactly NUM_PIXELS samples are stored, in arrival order, and the block then goes idle. `sample_valid_i` at any other time stores nothing.
- R7: `ready_o` is 1 exactly when the buffer holds at least one unread word, from the clock edge that stores a word.
- R8: A pop while the buffer is not empty places the oldest unread word on `spi_data_o` after the next clock edge. A pop while the buffer is empty leaves `spi_data_o` unchanged.
- R9: A start edge during setup, integration or readout aborts the scan, clears the buffer (`ready_o` becomes 0) and restarts from setup. A pop in the same cycle as the start edge is ignored.
- R10: After reset `integ_o`, `xfer_o` and `ready_o` are 0, `spi_data_o` is 0, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_rst_i | input | 1 | Start source A (buffer clear), rising edge |
| trig_i | input | 1 | Start source B (external trigger), rising edge |
| int_ms_i | input | INT_W | Integration time in milliseconds (0 means 1) |
| sample_valid_i | input | 1 | ADC sample strobe |
| sample_data_i | input | DATA_W | ADC sample value |
| pop_i | input | 1 | Moves the next buffered word to the holding register |
| integ_o | output | 1 | Integration window active |
| xfer_o | output | 1 | Sensor pixel transfer or reset in progress |
| ready_o | output | 1 | Unread pixel word waiting |
| spi_data_o | output | DATA_W | Holding register for the serial read |

## Verification
The bench applies a start edge while a source is already held high, and expects no new scan: a design that detects levels instead of edges would restart without end. It uses a zero integration value and expects a one-millisecond window; a design that loads zero unchanged would wrap its millisecond count and integrate for about 65 seconds. It sends start edges in the middle of integration and in the middle of readout. A design that does not clear the buffer would leave `ready_o` high with stale words, and one that does not reload its counters would shorten the next window. Pops on an empty buffer must not change `spi_data_o`, and samples that arrive outside readout must not change the pixel count.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_INTEG = 2'd2,
    ST_READ  = 2'd3
  } acq_state_e;
endpackage

// File: rtl/acq_edge_detect.sv
module acq_edge_detect #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic         any_rise_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_rise
    assign rise[g] = sig_i[g] & ~prev_q[g];
  end

  assign any_rise_o = |rise;
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int SETUP_CYCLES = 40,
  parameter int MS_CYCLES    = 48000,
  parameter int XFER_CYCLES  = 144,
  parameter int NUM_PIXELS   = 2048,
  parameter int INT_W        = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [INT_W-1:0] int_ms_i,
  input  logic             sample_valid_i,
  output logic             push_o,
  output logic             integ_o,
  output logic             xfer_o
);
  localparam int SET_W = $clog2(SETUP_CYCLES + 1);
  localparam int PRE_W = $clog2(MS_CYCLES + 1);
  localparam int XFR_W = $clog2(XFER_CYCLES + 1);
  localparam int PIX_W = $clog2(NUM_PIXELS + 1);

  acq_state_e       state_q;
  logic [SET_W-1:0] set_q;
  logic [PRE_W-1:0] pre_q;
  logic [INT_W-1:0] ms_q;
  logic [XFR_W-1:0] xfr_q;
  logic [PIX_W-1:0] pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      set_q   <= '0;
      pre_q   <= '0;
      ms_q    <= '0;
      xfr_q   <= '0;
      pix_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_SETUP;
      set_q   <= SET_W'(SETUP_CYCLES - 1);
      xfr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_SETUP: begin
          if (set_q == '0) begin
            state_q <= ST_INTEG;
            ms_q    <= (int_ms_i == '0) ? INT_W'(1) : int_ms_i;  // zero -> 1 ms
            pre_q   <= PRE_W'(MS_CYCLES - 1);
            xfr_q   <= XFR_W'(XFER_CYCLES);
          end else begin
            set_q <= set_q - 1'b1;
          end
        end
        ST_INTEG: begin
          if (xfr_q != '0) xfr_q <= xfr_q - 1'b1;
          if (pre_q == '0) begin
            if (ms_q == INT_W'(1)) begin
              state_q <= ST_READ;
              pix_q   <= '0;
            end else begin
              ms_q  <= ms_q - 1'b1;
              pre_q <= PRE_W'(MS_CYCLES - 1);
            end
          end else begin
            pre_q <= pre_q - 1'b1;
          end
        end
        ST_READ: begin
          if (sample_valid_i) begin
            if (pix_q == PIX_W'(NUM_PIXELS - 1)) state_q <= ST_IDLE;
            pix_q <= pix_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign integ_o = (state_q == ST_INTEG);
  assign xfer_o  = (state_q == ST_INTEG) && (xfr_q != '0);
  assign push_o  = (state_q == ST_READ) && sample_valid_i && !start_i;

  a_r1_start_enters_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_SETUP));

  a_r2_setup_done_integ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP && set_q == '0 && !start_i) |=> integ_o);

  a_r5_xfer_at_window_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(integ_o) |-> (xfer_o || XFER_CYCLES == 0));
endmodule

// File: rtl/acq_fifo.sv
module acq_fifo #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              nonempty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;
  logic              do_pop, do_push;

  assign do_pop  = pop_i && (cnt_q != '0) && !flush_i;
  assign do_push = push_i && !flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      rdata_o <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop) begin
        rdata_o <= mem_q[rd_q];
        rd_q    <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assign nonempty_o = (cnt_q != '0);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CW'(DEPTH)));

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !nonempty_o);

  a_r8_empty_pop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !nonempty_o) |=> $stable(rdata_o));
endmodule

// File: rtl/spec_acq_seq.sv
module spec_acq_seq #(
  parameter int SETUP_CYCLES = 40,
  parameter int MS_CYCLES    = 48000,
  parameter int XFER_CYCLES  = 144,
  parameter int NUM_PIXELS   = 2048,
  parameter int INT_W        = 16,
  parameter int DATA_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_rst_i,
  input  logic              trig_i,
  input  logic [INT_W-1:0]  int_ms_i,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] sample_data_i,
  input  logic              pop_i,
  output logic              integ_o,
  output logic              xfer_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] spi_data_o
);
  logic start, push;

  acq_edge_detect #(.N(2)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sig_i      ({trig_i, fifo_rst_i}),
    .any_rise_o (start)
  );

  acq_ctrl #(
    .SETUP_CYCLES (SETUP_CYCLES),
    .MS_CYCLES    (MS_CYCLES),
    .XFER_CYCLES  (XFER_CYCLES),
    .NUM_PIXELS   (NUM_PIXELS),
    .INT_W        (INT_W)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .int_ms_i       (int_ms_i),
    .sample_valid_i (sample_valid_i),
    .push_o         (push),
    .integ_o        (integ_o),
    .xfer_o         (xfer_o)
  );

  acq_fifo #(.DEPTH(NUM_PIXELS), .DATA_W(DATA_W)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (start),
    .push_i     (push),
    .wdata_i    (sample_data_i),
    .pop_i      (pop_i),
    .rdata_o    (spi_data_o),
    .nonempty_o (ready_o)
  );
endmodule

// File: tb/spec_acq_seq_bench.sv
module spec_acq_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP = 4;
  localparam int MS    = 10;
  localparam int XFER  = 3;
  localparam int NPIX  = 8;
  localparam int W     = 16;

  logic clk = 0, rst_n = 0;
  logic fifo_rst = 0, trig = 0, valid = 0, pop = 0;
  logic [15:0] int_ms = 0;
  logic [W-1:0] sdata = 0;
  logic integ, xfer, ready;
  logic [W-1:0] dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_acq_seq #(
    .SETUP_CYCLES(SETUP), .MS_CYCLES(MS), .XFER_CYCLES(XFER),
    .NUM_PIXELS(NPIX), .INT_W(16), .DATA_W(W)
  ) u_spec_acq_seq (
    .clk_i(clk), .rst_ni(rst_n), .fifo_rst_i(fifo_rst), .trig_i(trig),
    .int_ms_i(int_ms), .sample_valid_i(valid), .sample_data_i(sdata),
    .pop_i(pop), .integ_o(integ), .xfer_o(xfer), .ready_o(ready),
    .spi_data_o(dout)
  );

  int tests = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  int m_st = 0, m_set = 0, m_pre = 0, m_ms = 0, m_xfr = 0, m_pix = 0;
  int m_hold = 0;
  bit p_trig = 0, p_frst = 0;
  int q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_hold = 0; q.delete(); p_trig = 0; p_frst = 0; m_xfr = 0;
    end else begin
      bit rise;
      rise = (trig && !p_trig) || (fifo_rst && !p_frst);
      p_trig = trig; p_frst = fifo_rst;
      if (rise) begin
        q.delete(); m_st = 1; m_set = SETUP - 1; m_xfr = 0;
      end else begin
        if (pop && q.size() > 0) m_hold = q.pop_front();
        case (m_st)
          1: if (m_set == 0) begin
               m_st = 2; m_ms = (int_ms == 0) ? 1 : int'(int_ms);
               m_pre = MS - 1; m_xfr = XFER;
             end else m_set--;
          2: begin
               if (m_xfr > 0) m_xfr--;
               if (m_pre == 0) begin
                 if (m_ms == 1) begin m_st = 3; m_pix = 0; end
                 else begin m_ms--; m_pre = MS - 1; end
               end else m_pre--;
             end
          3: if (valid) begin
               q.push_back(int'(sdata));
               if (m_pix == NPIX - 1) m_st = 0;
               m_pix++;
             end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison and run-length monitors
  int integ_runs = 0, integ_len = 0, last_integ = 0, xfer_len = 0, last_xfer = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(integ == (m_st == 2), "R3 integ_o", int'(integ), int'(m_st == 2));
      chk(xfer == (m_st == 2 && m_xfr != 0), "R5 xfer_o", int'(xfer), int'(m_st == 2 && m_xfr != 0));
      chk(ready == (q.size() != 0), "R7 ready_o", int'(ready), int'(q.size() != 0));
      chk(int'(dout) == m_hold, "R8 spi_data_o", int'(dout), m_hold);
      if (integ) integ_len++;
      else if (integ_len != 0) begin last_integ = integ_len; integ_len = 0; integ_runs++; end
      if (xfer) xfer_len++;
      else if (xfer_len != 0) begin last_xfer = xfer_len; xfer_len = 0; end
    end
  end

  // sample source: continuous or every other cycle
  bit feed_on = 0, feed_gap = 0;
  always @(negedge clk) begin
    valid = feed_on && (!feed_gap || cyc[0]);
    if (valid) sdata = sdata + 16'h0101;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
  endtask

  initial begin
    int n;
    int runs0;
    int held;
    wait_cycles(3);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!integ && !xfer, "R10 idle outputs", int'(integ | xfer), 0);
    chk(!ready, "R10 ready", int'(ready), 0);
    chk(dout == 0, "R10 data", int'(dout), 0);

    // samples arriving while idle are ignored (R6)
    feed_on = 1; wait_cycles(5);
    chk(!ready, "R6 idle samples ignored", int'(ready), 0);

    // scan 1 via trigger, 2 ms
    int_ms = 2;
    trig = 1;
    @(posedge clk);
    repeat (SETUP - 1) @(posedge clk);
    @(negedge clk);
    chk(!integ, "R2 still in setup", int'(integ), 0);
    chk(!ready, "R6 no store before readout", int'(ready), 0);
    @(negedge clk);
    chk(integ, "R2 integ after setup", int'(integ), 1);
    while (integ) @(negedge clk);
    @(negedge clk);
    chk(last_integ == 2 * MS, "R3 window length", last_integ, 2 * MS);
    chk(last_xfer == XFER, "R5 transfer length", last_xfer, XFER);
    wait_cycles(NPIX + 6);
    // held-high trigger must not restart (R1)
    runs0 = integ_runs;
    wait_cycles(30);
    chk(integ_runs == runs0 && !integ, "R1 held level no restart", integ_runs, runs0);
    // drain: exactly NPIX words (R6)
    n = 0;
    while (ready && n < 3 * NPIX) begin do_pop(); n++; end
    chk(n == NPIX, "R6 word count", n, NPIX);
    held = int'(dout);
    do_pop(); do_pop();
    chk(int'(dout) == held, "R8 empty pop holds", int'(dout), held);

    // scan 2 via buffer-clear source, int=0 -> 1 ms, gapped samples
    trig = 0; feed_gap = 1; int_ms = 0;
    @(negedge clk); fifo_rst = 1;
    while (!integ) @(negedge clk);
    while (integ) @(negedge clk);
    @(negedge clk);
    chk(last_integ == MS, "R4 zero gives 1 ms", last_integ, MS);
    chk(integ_runs == runs0 + 1, "R1 second source starts", integ_runs, runs0 + 1);
    wait_cycles(6);
    do_pop();
    chk(ready, "R7 words still unread", int'(ready), 1);
    // abort in readout with pop in same cycle (R9)
    fifo_rst = 0;
    @(negedge clk); trig = 1; pop = 1;
    @(negedge clk); pop = 0;
    chk(!ready, "R9 abort flushes", int'(ready), 0);
    // abort during integration (R9)
    int_ms = 3;
    while (!integ) @(negedge clk);
    wait_cycles(7);
    trig = 0; @(negedge clk); trig = 1;
    @(negedge clk);
    chk(!integ, "R9 integ aborted", int'(integ), 0);
    while (!integ) @(negedge clk);
    while (integ) @(negedge clk);
    @(negedge clk);
    chk(last_integ == 3 * MS, "R9 fresh full window", last_integ, 3 * MS);
    wait_cycles(2 * NPIX + 6);
    n = 0;
    while (ready && n < 3 * NPIX) begin do_pop(); n++; end
    chk(n == NPIX, "R6 gapped word count", n, NPIX);
    wait_cycles(5);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule